// File: doc/BRIEF.md
# Load/Store to System Bus Bridge Arbiter

This block joins a processor's load/store bus to a shared system bus and moves traffic in both directions. A processor request whose address lies outside the local data RAM window is passed on as a cycle on the system bus. The processor's read data and completion come back from that cycle. A system-bus master that addresses the RAM window is served directly from the local RAM port.

Only one transfer is in flight at a time. When both sides present a request in the same idle cycle, the inbound system-bus access always wins. The processor request is held off and is served later. A lock input shuts the system side out of the RAM: locked accesses are answered with an error and never write. Neither side can complete two transfers in adjacent cycles. An outbound cycle is only launched while the system bus reports a pipeline depth of zero or one.

The controller is a four-state machine:
- **ST_IDLE** (after reset): decides what to do next.
- **ST_IDLE → ST_IN_RAM**: an inbound hit arrives with the lock clear.
- **ST_IDLE → ST_IN_DENY**: an inbound hit arrives with the lock set.
- **ST_IDLE → ST_OUT**: a forwardable processor request is present, no inbound hit is present, and the pipe depth allows it.
- **ST_OUT → ST_IDLE**: on the system-bus acknowledge.
- **ST_IN_RAM → ST_IDLE** and **ST_IN_DENY → ST_IDLE**: unconditionally, after one cycle.

Top module: `bus_bridge_arb`

## Requirements
- R1: After reset, sout_req, cpu_ack, sin_ack, sin_err and ram_we are all 0.
- R2: A processor request outside the RAM window drives sout_req with the processor's address, write flag and write data. cpu_ack and cpu_rdata follow sout_ack and sout_rdata. sout_req stays high until sout_ack.
- R3: A processor request inside the RAM window is ignored. It raises no sout_req and no cpu_ack.
- R4: With the lock clear, an inbound request inside the window is acknowledged for one cycle with sin_err=0. A read returns the RAM word at index addr[LOG2-1:2]. A write stores sin_wdata at that index.
- R5: With the lock set, an inbound request inside the window is acknowledged with sin_err=1. ram_we stays 0 and the RAM is unchanged.
- R6: When both sides request in the same idle cycle, the inbound access completes first. The processor request is stalled, not dropped, and completes afterwards.
- R7: sout_req is low for at least one cycle after every completed outbound cycle. A held processor request is therefore served at most every second cycle.
- R8: sin_ack is never high in two consecutive cycles, even when the master holds its request.
- R9: An outbound cycle starts only if sys_pipe_depth was at most 1 in the deciding cycle. With a greater depth the processor request waits.
- R10: An inbound request outside the RAM window is never acknowledged.
- R11: sout_req and sin_ack are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_lock | input | 1 | Blocks system-side RAM access when 1 |
| cpu_req | input | 1 | Processor load/store request, held until cpu_ack |
| cpu_we | input | 1 | Processor write flag |
| cpu_addr | input | AW | Processor byte address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ack | output | 1 | Processor transfer complete |
| cpu_rdata | output | DW | Processor read data |
| sout_req | output | 1 | Outbound system-bus cycle active |
| sout_we | output | 1 | Outbound write flag |
| sout_addr | output | AW | Outbound address |
| sout_wdata | output | DW | Outbound write data |
| sout_ack | input | 1 | System-bus slave completion |
| sout_rdata | input | DW | System-bus slave read data |
| sys_pipe_depth | input | PD_W | Current system-bus pipeline depth |
| sin_req | input | 1 | Inbound master request, held until sin_ack |
| sin_we | input | 1 | Inbound write flag |
| sin_addr | input | AW | Inbound byte address |
| sin_wdata | input | DW | Inbound write data |
| sin_ack | output | 1 | Inbound completion |
| sin_err | output | 1 | Inbound completion carries an error |
| sin_rdata | output | DW | Inbound read data |
| ram_en | output | 1 | Local RAM access strobe |
| ram_we | output | 1 | Local RAM write strobe |
| ram_addr | output | LOG2-2 | Local RAM word index |
| ram_wdata | output | DW | Local RAM write data |
| ram_rdata | input | DW | Local RAM read data (combinational) |

## Verification
The assertions watch several rules on every cycle:
- the spacing rules: no adjacent inbound acknowledges, and a low sout_req after each outbound completion;
- the pipe-depth gate on each outbound start;
- the exclusion between outbound and inbound activity;
- the absence of RAM writes on error responses;
- the holding of an outbound cycle until its acknowledge.

Some behaviour only the bench scenarios can show:
- that data really travels end to end, and that RAM contents survive a locked write;
- that in-window processor and out-of-window inbound requests are ignored;
- that a simultaneous pair completes in the stated order;
- that the stalled processor request is eventually served.

// File: rtl/bba_pkg.sv
package bba_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_OUT     = 2'd1,
        ST_IN_RAM  = 2'd2,
        ST_IN_DENY = 2'd3
    } bba_state_e;

endpackage

// File: rtl/bba_win_dec.sv
module bba_win_dec #(
    parameter int              AW   = 32,
    parameter int              LOG2 = 12,
    parameter logic [AW-1:0]   BASE = 32'h0040_0000,
    localparam int             IW   = LOG2 - 2
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [IW-1:0] idx
);
    logic unused_lsb;

    // Window is naturally aligned: compare the bits above the window size.
    assign hit        = (addr[AW-1:LOG2] == BASE[AW-1:LOG2]);
    assign idx        = addr[LOG2-1:2];
    assign unused_lsb = ^addr[1:0];
endmodule

// File: rtl/bba_ctrl.sv
module bba_ctrl
    import bba_pkg::*;
#(
    parameter int PD_W     = 2,
    parameter int MAX_PIPE = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_go,
    input  logic            in_we,
    input  logic            lock,
    input  logic            out_go,
    input  logic [PD_W-1:0] pipe_depth,
    input  logic            sout_ack,
    output logic            sout_req,
    output logic            cpu_ack,
    output logic            sin_ack,
    output logic            sin_err,
    output logic            ram_en,
    output logic            ram_we
);
    localparam logic [PD_W-1:0] PIPE_LIM = PD_W'(MAX_PIPE);

    bba_state_e state_q, state_d;
    logic       pipe_ok;

    assign pipe_ok = (pipe_depth <= PIPE_LIM);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_go)                state_d = lock ? ST_IN_DENY : ST_IN_RAM;
                else if (out_go && pipe_ok) state_d = ST_OUT;
            end
            ST_OUT:     if (sout_ack) state_d = ST_IDLE;
            ST_IN_RAM:  state_d = ST_IDLE;
            ST_IN_DENY: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sout_req = 1'b0;
        cpu_ack  = 1'b0;
        sin_ack  = 1'b0;
        sin_err  = 1'b0;
        ram_en   = 1'b0;
        ram_we   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_OUT: begin
                sout_req = 1'b1;
                cpu_ack  = sout_ack;
            end
            ST_IN_RAM: begin
                sin_ack = 1'b1;
                ram_en  = 1'b1;
                ram_we  = in_we;
            end
            ST_IN_DENY: begin
                sin_ack = 1'b1;
                sin_err = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_bridge_arb.sv
module bus_bridge_arb #(
    parameter int            AW       = 32,
    parameter int            DW       = 32,
    parameter int            LOG2     = 12,
    parameter logic [AW-1:0] RAM_BASE = 32'h0040_0000,
    parameter int            PD_W     = 2,
    parameter int            MAX_PIPE = 1,
    localparam int           IW       = LOG2 - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ram_lock,
    input  logic            cpu_req,
    input  logic            cpu_we,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    output logic            cpu_ack,
    output logic [DW-1:0]   cpu_rdata,
    output logic            sout_req,
    output logic            sout_we,
    output logic [AW-1:0]   sout_addr,
    output logic [DW-1:0]   sout_wdata,
    input  logic            sout_ack,
    input  logic [DW-1:0]   sout_rdata,
    input  logic [PD_W-1:0] sys_pipe_depth,
    input  logic            sin_req,
    input  logic            sin_we,
    input  logic [AW-1:0]   sin_addr,
    input  logic [DW-1:0]   sin_wdata,
    output logic            sin_ack,
    output logic            sin_err,
    output logic [DW-1:0]   sin_rdata,
    output logic            ram_en,
    output logic            ram_we,
    output logic [IW-1:0]   ram_addr,
    output logic [DW-1:0]   ram_wdata,
    input  logic [DW-1:0]   ram_rdata
);
    logic          cpu_hit, sin_hit;
    logic [IW-1:0] cpu_unused_idx;
    logic          in_go, out_go;

    bba_win_dec #(.AW(AW), .LOG2(LOG2), .BASE(RAM_BASE)) u_cpu_dec (
        .addr(cpu_addr), .hit(cpu_hit), .idx(cpu_unused_idx)
    );

    bba_win_dec #(.AW(AW), .LOG2(LOG2), .BASE(RAM_BASE)) u_sin_dec (
        .addr(sin_addr), .hit(sin_hit), .idx(ram_addr)
    );

    assign in_go  = sin_req && sin_hit;
    assign out_go = cpu_req && !cpu_hit;

    bba_ctrl #(.PD_W(PD_W), .MAX_PIPE(MAX_PIPE)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_go      (in_go),
        .in_we      (sin_we),
        .lock       (ram_lock),
        .out_go     (out_go),
        .pipe_depth (sys_pipe_depth),
        .sout_ack   (sout_ack),
        .sout_req   (sout_req),
        .cpu_ack    (cpu_ack),
        .sin_ack    (sin_ack),
        .sin_err    (sin_err),
        .ram_en     (ram_en),
        .ram_we     (ram_we)
    );

    assign sout_we    = cpu_we;
    assign sout_addr  = cpu_addr;
    assign sout_wdata = cpu_wdata;
    assign cpu_rdata  = sout_rdata;
    assign sin_rdata  = ram_rdata;
    assign ram_wdata  = sin_wdata;
endmodule

// File: rtl/bus_bridge_arb_chk.sv
module bus_bridge_arb_chk #(
    parameter int PD_W     = 2,
    parameter int MAX_PIPE = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sout_req,
    input logic            sout_ack,
    input logic            cpu_ack,
    input logic            sin_ack,
    input logic            sin_err,
    input logic            ram_we,
    input logic [PD_W-1:0] sys_pipe_depth
);
    localparam logic [PD_W-1:0] LIM = PD_W'(MAX_PIPE);

    a_r8_no_adjacent_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        sin_ack |=> !sin_ack);

    a_r7_out_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (sout_req && sout_ack) |=> !sout_req);

    a_r9_pipe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sout_req) |-> ($past(sys_pipe_depth) <= LIM));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sout_req && sin_ack));

    a_r5_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        sin_err |-> (sin_ack && !ram_we));

    a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (sout_req && !sout_ack) |=> sout_req);

    a_r2_ack_source: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> (sout_req && sout_ack));
endmodule

bind bus_bridge_arb bus_bridge_arb_chk #(.PD_W(PD_W), .MAX_PIPE(MAX_PIPE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sout_req       (sout_req),
    .sout_ack       (sout_ack),
    .cpu_ack        (cpu_ack),
    .sin_ack        (sin_ack),
    .sin_err        (sin_err),
    .ram_we         (ram_we),
    .sys_pipe_depth (sys_pipe_depth)
);

// File: tb/test_bus_bridge_arb.sv
module test_bus_bridge_arb;
    localparam int            AW    = 32;
    localparam int            DW    = 32;
    localparam int            LOG2  = 12;
    localparam int            IW    = LOG2 - 2;
    localparam int            WORDS = 1 << IW;
    localparam logic [AW-1:0] BASE  = 32'h0040_0000;

    logic clk = 1'b0, rst_n = 1'b0, ram_lock = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_ack;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
    logic sout_req, sout_we, sout_ack;
    logic [AW-1:0] sout_addr;
    logic [DW-1:0] sout_wdata, sout_rdata;
    logic [1:0] sys_pipe_depth = 2'd0;
    logic sin_req = 1'b0, sin_we = 1'b0, sin_ack, sin_err;
    logic [AW-1:0] sin_addr = '0;
    logic [DW-1:0] sin_wdata = '0, sin_rdata;
    logic ram_en, ram_we;
    logic [IW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata, ram_rdata;

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] model [WORDS];
    int n_chk = 0, n_fail = 0, cyc = 0;
    int out_lat = 0, lat_cnt = 0, out_starts = 0;
    int adj_in = 0, gap_bad = 0, overlap = 0;
    logic prev_sin_ack = 1'b0, prev_done = 1'b0, prev_sout_req = 1'b0;
    logic [AW-1:0] seen_addr;
    logic [DW-1:0] seen_wdata;
    logic seen_we;

    bus_bridge_arb i_bus_bridge_arb (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] slv_data(input logic [AW-1:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    function automatic logic [AW-1:0] far_addr(input logic [AW-1:0] a);
        logic [AW-1:0] r = a;
        if (r[AW-1:LOG2] == BASE[AW-1:LOG2]) r[20] = ~r[20];
        return r;
    endfunction

    // Behavioural RAM and system-bus slave
    assign ram_rdata  = mem[ram_addr];
    assign sout_ack   = sout_req && (lat_cnt == 0);
    assign sout_rdata = slv_data(sout_addr);
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (!sout_req) lat_cnt <= out_lat;
        else if (lat_cnt != 0) lat_cnt <= lat_cnt - 1;
    end

    // Port monitors, sampled away from the active edge
    always @(negedge clk) if (rst_n) begin
        if (sin_ack && prev_sin_ack) adj_in++;
        if (prev_done && sout_req) gap_bad++;
        if (sout_req && sin_ack) overlap++;
        if (sout_req && !prev_sout_req) out_starts++;
        if (sout_req && sout_ack) begin
            seen_addr = sout_addr; seen_we = sout_we; seen_wdata = sout_wdata;
        end
        prev_sin_ack  = sin_ack;
        prev_done     = sout_req && sout_ack;
        prev_sout_req = sout_req;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_xfer(input logic [AW-1:0] a, input logic we, input logic [DW-1:0] wd,
                            input int limit, output logic [DW-1:0] rd, output bit ok, output int when);
        ok = 0; rd = '0; when = 0;
        @(negedge clk);
        cpu_req = 1; cpu_addr = a; cpu_we = we; cpu_wdata = wd;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (cpu_ack) begin ok = 1; rd = cpu_rdata; when = cyc; break; end
        end
        if (ok) @(negedge clk);
        cpu_req = 0;
    endtask

    task automatic sys_xfer(input logic [AW-1:0] a, input logic we, input logic [DW-1:0] wd,
                            input int limit, output logic [DW-1:0] rd, output bit ok,
                            output bit err, output int when);
        ok = 0; err = 0; rd = '0; when = 0;
        @(negedge clk);
        sin_req = 1; sin_addr = a; sin_we = we; sin_wdata = wd;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (sin_ack) begin ok = 1; err = sin_err; rd = sin_rdata; when = cyc; break; end
        end
        if (ok) @(negedge clk);
        sin_req = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        bit ok, err;
        int t_in, t_cpu, cnt, st0;
        logic [AW-1:0] a;
        void'($urandom(32'd2718));
        for (int i = 0; i < WORDS; i++) begin
            mem[i] = i * 32'h0101_0007; model[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1: reset values
        check(!sout_req && !cpu_ack && !sin_ack && !sin_err && !ram_we, "R1 reset outputs",
              {27'd0, sout_req, cpu_ack, sin_ack, sin_err, ram_we}, 0);
        rst_n = 1;

        // R2: forwarded read and write
        out_lat = 2;
        cpu_xfer(32'h1000_0010, 0, 0, 10, rd, ok, t_cpu);
        check(ok && rd == slv_data(32'h1000_0010), "R2 outbound read data", rd, slv_data(32'h1000_0010));
        check(seen_addr == 32'h1000_0010 && !seen_we, "R2 outbound address", seen_addr, 32'h1000_0010);
        out_lat = 0;
        cpu_xfer(32'h2000_0ABC, 1, 32'hCAFE_0001, 10, rd, ok, t_cpu);
        check(ok && seen_we && seen_wdata == 32'hCAFE_0001, "R2 outbound write data", seen_wdata, 32'hCAFE_0001);

        // R4: inbound write then read, lock clear
        sys_xfer(BASE + 32'h40, 1, 32'h1234_5678, 10, rd, ok, err, t_in);
        model[16] = 32'h1234_5678;
        check(ok && !err, "R4 inbound write ack", {30'd0, ok, err}, 2);
        sys_xfer(BASE + 32'h40, 0, 0, 10, rd, ok, err, t_in);
        check(ok && !err && rd == 32'h1234_5678, "R4 inbound read data", rd, 32'h1234_5678);

        // R5: locked write refused, contents kept
        ram_lock = 1;
        sys_xfer(BASE + 32'h40, 1, 32'hDEAD_BEEF, 10, rd, ok, err, t_in);
        check(ok && err, "R5 locked write error", {30'd0, ok, err}, 3);
        ram_lock = 0;
        sys_xfer(BASE + 32'h40, 0, 0, 10, rd, ok, err, t_in);
        check(rd == 32'h1234_5678, "R5 RAM unchanged after locked write", rd, 32'h1234_5678);

        // R3: processor request inside the window is ignored
        st0 = out_starts;
        cpu_xfer(BASE + 32'h8, 0, 0, 6, rd, ok, t_cpu);
        check(!ok && out_starts == st0, "R3 in-window request ignored", out_starts - st0, 0);

        // R10: inbound request outside the window is ignored
        sys_xfer(32'h0080_0000, 0, 0, 6, rd, ok, err, t_in);
        check(!ok, "R10 out-of-window inbound ignored", {31'd0, ok}, 0);

        // R9: pipe depth 2 holds the processor off
        st0 = out_starts; cnt = 0;
        sys_pipe_depth = 2'd2;
        @(negedge clk); cpu_req = 1; cpu_addr = 32'h3000_0000; cpu_we = 0;
        repeat (6) begin @(negedge clk); if (cpu_ack) cnt++; end
        check(cnt == 0 && out_starts == st0, "R9 no start at depth 2", out_starts - st0, 0);
        sys_pipe_depth = 2'd1;
        repeat (3) begin @(negedge clk); if (cpu_ack) cnt++; if (cpu_ack) break; end
        check(cnt == 1, "R9 start at depth 1", cnt, 1);
        @(negedge clk); cpu_req = 0; sys_pipe_depth = 2'd0;

        // R6: simultaneous requests, inbound first, processor not dropped
        out_lat = 1;
        fork
            cpu_xfer(32'h4000_0100, 0, 0, 20, rd, ok, t_cpu);
            begin
                logic [DW-1:0] r2; bit o2, e2;
                sys_xfer(BASE + 32'h44, 0, 0, 20, r2, o2, e2, t_in);
                check(o2 && r2 == model[17], "R6 inbound served", r2, model[17]);
            end
        join
        check(ok && t_in < t_cpu, "R6 processor after inbound", t_cpu, t_in + 2);

        // R8: master holds its request; acks alternate
        cnt = 0;
        @(negedge clk); sin_req = 1; sin_addr = BASE; sin_we = 0;
        repeat (6) begin @(negedge clk); if (sin_ack) cnt++; end
        sin_req = 0;
        check(cnt == 3, "R8 held inbound acks every other cycle", cnt, 3);

        // R7: processor holds its request, zero latency slave
        out_lat = 0; cnt = 0;
        @(negedge clk); cpu_req = 1; cpu_addr = 32'h5000_0000; cpu_we = 0;
        repeat (6) begin @(negedge clk); if (cpu_ack) cnt++; end
        cpu_req = 0;
        check(cnt == 3, "R7 held outbound completes every other cycle", cnt, 3);

        // Random mix
        for (int it = 0; it < 80; it++) begin
            int op = $urandom_range(3);
            logic [DW-1:0] wd = $urandom;
            int idx = $urandom_range(WORDS - 1);
            out_lat = $urandom_range(2);
            ram_lock = ($urandom_range(3) == 0);
            if (op < 2) begin
                a = far_addr($urandom);
                cpu_xfer(a, op[0], wd, 10, rd, ok, t_cpu);
                if (op[0]) check(ok && seen_wdata == wd && seen_addr == a, "R2 random write", seen_wdata, wd);
                else       check(ok && rd == slv_data(a), "R2 random read", rd, slv_data(a));
            end else begin
                a = BASE + (idx << 2);
                sys_xfer(a, op[0], wd, 10, rd, ok, err, t_in);
                if (ram_lock) check(ok && err, "R5 random locked", {30'd0, ok, err}, 3);
                else if (op[0]) begin
                    model[idx] = wd;
                    check(ok && !err, "R4 random write", {30'd0, ok, err}, 2);
                end else check(ok && !err && rd == model[idx], "R4 random read", rd, model[idx]);
            end
        end
        ram_lock = 0;
        for (int i = 0; i < 8; i++) begin
            sys_xfer(BASE + (i << 2), 0, 0, 10, rd, ok, err, t_in);
            check(rd == model[i], "R4 final RAM content", rd, model[i]);
        end

        check(adj_in == 0, "R8 no adjacent inbound acks", adj_in, 0);
        check(gap_bad == 0, "R7 idle after every outbound completion", gap_bad, 0);
        check(overlap == 0, "R11 outbound and inbound never together", overlap, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule